// File: doc/BRIEF.md
# Serial Block-Write Configuration Slave

This block sits on a two-wire serial bus as a write-only slave and holds a small bank of byte-wide clock-control settings. A host opens a transfer with a start condition, sends the device address, a command byte and a byte-count byte, and then sends up to that many data bytes. The data bytes land in the register bank starting at index 0 and moving upward. The slave samples the bus lines with its own system clock after two-flop synchronizers. It answers each accepted byte by pulling the data line low during the acknowledge bit, and it never drives the line high.

Register 0 is the control byte. Its writable bits drive three decoded outputs: spread enable, a 66/48 MHz select and a PCI run control. Its other bits are either fixed reserved values or copies of two strap inputs that are captured while reset is held. The other registers are general bytes that reset to zero. After reset every register already holds a usable value, so a system may leave the bus unused.

Top module: `cfgwr_slave`

## Requirements
- R1: While `rst` is high and after it falls, register 0 reads {0,0,0,1,1,strap_s2,strap_s1,1} (bit 7 down to bit 0), and every other register reads 0x00. `regs_o[8*k+7:8*k]` is register k.
- R2: The slave acknowledges the first byte after a start only when that byte is 0xD2, which is 7-bit address 0x69 with a direction bit of 0. Any other address byte, including the read byte 0xD3, is not acknowledged.
- R3: The byte after an acknowledged address is acknowledged only when it is 0x00. Any other command byte is not acknowledged.
- R4: The byte after the command is the byte count. It is acknowledged only for values 1 to 32. A count of 0 or a count above 32 is not acknowledged.
- R5: Data bytes are received MSB first and written to registers 0, 1, 2 and so on in that order. Every start condition restarts at register 0. A host write to register 0 changes only bits 7, 5 and 3, while bits 6, 4 and 0 stay 0, 1 and 1.
- R6: A stop condition after any complete data byte ends the transfer. Registers written before the stop keep their new values, and registers that were not reached keep their old values.
- R7: Data bytes within the count but past the last implemented register are acknowledged and discarded. A data byte beyond the byte count is not acknowledged and is not stored.
- R8: Register 0 bits 2 and 1 hold strap_s2 and strap_s1 as captured during reset. Later strap changes and host writes leave them unchanged.
- R9: After a byte that is not acknowledged, the slave acknowledges nothing and writes nothing until the next start condition.
- R10: `spread_en` equals register 0 bit 7, `sel_48m` equals bit 5 and `pci_run` equals bit 3.
- R11: `sda_oe` is asserted only during an acknowledge bit. It turns on while SCL is low and does not change while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge); 0 releases it |
| strap_s2 | input | 1 | Strap input reported in register 0 bit 2 |
| strap_s1 | input | 1 | Strap input reported in register 0 bit 1 |
| regs_o | output | 8*NUM_REGS | Register bank, with register k in bits 8k+7..8k |
| spread_en | output | 1 | Spread-spectrum enable, decoded from register 0 |
| sel_48m | output | 1 | 1 selects 48 MHz and 0 selects 66 MHz on the shared output |
| pci_run | output | 1 | 1 lets the PCI clocks run and 0 stops them |

## Verification
The bench sends the wrong address, a read request, a nonzero command and the counts 0, 32 and 33. A design that checked the wrong field, or got an off-by-one in the count range, would acknowledge the wrong byte and write registers it should leave alone. It also sends transfers that stop after one byte, run past the implemented registers, run past their own count, and restart without a stop. These catch a design that stores discarded bytes, acknowledges past the count, or resumes at the old index instead of register 0. The last tests write zeros over the reserved and strap bits and change the straps after reset, which exposes a design with a wrong write mask or with straps that follow the pins.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_IGN
  } bus_state_e;

  // register 0: host-writable positions and fixed reserved pattern
  localparam logic [7:0] CTRL_WMASK = 8'hA8;
  localparam logic [4:0] CTRL_HI_RST = 5'b00011;
endpackage

// File: rtl/cfgwr_sync.sv
module cfgwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '1;
    else     ff_q <= {ff_q[STAGES-2:0], din};
  end

  assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/cfgwr_proto.sv
module cfgwr_proto
  import cfgwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] CMD_CODE  = 8'h00,
  parameter int         MAX_COUNT = 32,
  parameter int         NUM_REGS  = 4,
  localparam int        CW        = $clog2(MAX_COUNT + 1),
  localparam int        RW        = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [RW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          ignoring
);
  localparam logic [7:0]    MAXC8  = 8'(MAX_COUNT);
  localparam logic [CW-1:0] NREG_C = CW'(NUM_REGS);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  bus_state_e    state_q;
  logic          scl_d, sda_d;
  logic [3:0]    bitcnt_q;
  logic [7:0]    shreg_q;
  logic          in_ack_q, ack_pend_q, oe_q;
  logic [CW-1:0] remain_q, idx_q;
  logic          wr_en_q;
  logic [RW-1:0] wr_idx_q;
  logic [7:0]    wr_data_q;

  logic       start_ev, stop_ev, scl_rise, scl_fall, shifting;
  logic [7:0] byte_w;

  assign start_ev = scl && scl_d && sda_d && !sda;
  assign stop_ev  = scl && scl_d && !sda_d && sda;
  assign scl_rise = scl && !scl_d;
  assign scl_fall = !scl && scl_d;
  assign byte_w   = {shreg_q[6:0], sda};
  assign shifting = !in_ack_q && (bitcnt_q != 4'd8) &&
                    (state_q inside {ST_ADDR, ST_CMD, ST_CNT, ST_DATA});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      in_ack_q   <= 1'b0;
      ack_pend_q <= 1'b0;
      oe_q       <= 1'b0;
      remain_q   <= '0;
      idx_q      <= '0;
      wr_en_q    <= 1'b0;
      wr_idx_q   <= '0;
      wr_data_q  <= '0;
    end else begin
      scl_d   <= scl;
      sda_d   <= sda;
      wr_en_q <= 1'b0;
      if (start_ev) begin
        state_q    <= ST_ADDR;
        bitcnt_q   <= '0;
        in_ack_q   <= 1'b0;
        ack_pend_q <= 1'b0;
        oe_q       <= 1'b0;
        idx_q      <= '0;
      end else if (stop_ev) begin
        state_q    <= ST_IDLE;
        bitcnt_q   <= '0;
        in_ack_q   <= 1'b0;
        ack_pend_q <= 1'b0;
        oe_q       <= 1'b0;
      end else if (scl_rise) begin
        if (shifting) begin
          shreg_q  <= byte_w;
          bitcnt_q <= bitcnt_q + 4'd1;
          if (bitcnt_q == 4'd7) begin
            unique case (state_q)
              ST_ADDR: begin
                if (byte_w == {DEV_ADDR, 1'b0}) begin
                  ack_pend_q <= 1'b1;
                  state_q    <= ST_CMD;
                end else state_q <= ST_IGN;
              end
              ST_CMD: begin
                if (byte_w == CMD_CODE) begin
                  ack_pend_q <= 1'b1;
                  state_q    <= ST_CNT;
                end else state_q <= ST_IGN;
              end
              ST_CNT: begin
                if (byte_w != 8'd0 && byte_w <= MAXC8) begin
                  ack_pend_q <= 1'b1;
                  remain_q   <= byte_w[CW-1:0];
                  state_q    <= ST_DATA;
                end else state_q <= ST_IGN;
              end
              default: begin
                if (remain_q != '0) begin
                  ack_pend_q <= 1'b1;
                  remain_q   <= remain_q - ONE_C;
                  idx_q      <= idx_q + ONE_C;
                  if (idx_q < NREG_C) begin
                    wr_en_q   <= 1'b1;
                    wr_idx_q  <= idx_q[RW-1:0];
                    wr_data_q <= byte_w;
                  end
                end else state_q <= ST_IGN;
              end
            endcase
          end
        end
      end else if (scl_fall) begin
        if (in_ack_q) begin
          oe_q     <= 1'b0;
          in_ack_q <= 1'b0;
          bitcnt_q <= '0;
        end else if (bitcnt_q == 4'd8) begin
          bitcnt_q <= '0;
          if (ack_pend_q) begin
            oe_q       <= 1'b1;
            in_ack_q   <= 1'b1;
            ack_pend_q <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe   = oe_q;
  assign wr_en    = wr_en_q;
  assign wr_idx   = wr_idx_q;
  assign wr_data  = wr_data_q;
  assign ignoring = (state_q == ST_IGN);
endmodule

// File: rtl/cfgwr_regbank.sv
module cfgwr_regbank
  import cfgwr_pkg::*;
#(
  parameter int  NUM_REGS = 4,
  localparam int RW       = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            strap,
  input  logic                  we,
  input  logic [RW-1:0]         widx,
  input  logic [7:0]            wdata,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] r_q;
    if (i == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)
          r_q <= {CTRL_HI_RST, strap, 1'b1};
        else if (we && widx == RW'(i))
          r_q <= (wdata & CTRL_WMASK) | (r_q & ~CTRL_WMASK);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                        r_q <= '0;
        else if (we && widx == RW'(i))  r_q <= wdata;
      end
    end
    assign regs_o[i*8 +: 8] = r_q;
  end
endmodule

// File: rtl/cfgwr_slave.sv
module cfgwr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] CMD_CODE    = 8'h00,
  parameter int         MAX_COUNT   = 32,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  strap_s2,
  input  logic                  strap_s1,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  spread_en,
  output logic                  sel_48m,
  output logic                  pci_run
);
  localparam int RW = $clog2(NUM_REGS);

  logic [1:0]    raw_lines, sync_lines;
  logic          scl_s, sda_s;
  logic          wr_en, bus_ign;
  logic [RW-1:0] wr_idx;
  logic [7:0]    wr_data;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    cfgwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(sync_lines[g])
    );
  end

  assign scl_s = sync_lines[1];
  assign sda_s = sync_lines[0];

  cfgwr_proto #(
    .DEV_ADDR (DEV_ADDR),
    .CMD_CODE (CMD_CODE),
    .MAX_COUNT(MAX_COUNT),
    .NUM_REGS (NUM_REGS)
  ) u_proto (
    .clk     (clk),
    .rst     (rst),
    .scl     (scl_s),
    .sda     (sda_s),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ignoring(bus_ign)
  );

  cfgwr_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .strap ({strap_s2, strap_s1}),
    .we    (wr_en),
    .widx  (wr_idx),
    .wdata (wr_data),
    .regs_o(regs_o)
  );

  assign spread_en = regs_o[7];
  assign sel_48m   = regs_o[5];
  assign pci_run   = regs_o[3];
endmodule

// File: rtl/cfgwr_chk.sv
module cfgwr_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  ign,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] regs
);
  assert_oe_on_low_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  assert_oe_steady_R11: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  assert_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    (regs[6] == 1'b0) && regs[4] && regs[0]);

  assert_strap_held_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(regs[2:1]));

  assert_quiet_after_nack_R9: assert property (@(posedge clk) disable iff (rst)
    ign |=> !sda_oe);

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));
endmodule

bind cfgwr_slave cfgwr_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .scl_s (scl_s),
  .sda_oe(sda_oe),
  .ign   (bus_ign),
  .wr_en (wr_en),
  .regs  (regs_o)
);

// File: tb/cfgwr_slave_tb.sv
module cfgwr_slave_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_h = 1'b1;
  logic        s2 = 1'b1;
  logic        s1 = 1'b0;
  logic        sda_oe;
  logic [31:0] regs;
  logic        spread_en, sel_48m, pci_run;
  logic        sda_line;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_h & ~sda_oe;

  cfgwr_slave u_dut (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .strap_s2 (s2),
    .strap_s1 (s1),
    .regs_o   (regs),
    .spread_en(spread_en),
    .sel_48m  (sel_48m),
    .pci_run  (pci_run)
  );

  // bytes[107:44] (byte 0 first), count[43:40], ack mask[39:32], bank[31:0]
  localparam logic [107:0] VECS [10] = '{
    {64'hD2_00_04_FF_11_22_33_00, 4'd7, 8'h7F, 32'h332211BD},
    {64'hD2_00_02_00_00_00_00_00, 4'd4, 8'h0F, 32'h33221115},
    {64'hD4_00_01_AA_00_00_00_00, 4'd4, 8'h00, 32'h33221115},
    {64'hD3_00_01_AA_00_00_00_00, 4'd4, 8'h00, 32'h33221115},
    {64'hD2_01_01_AA_00_00_00_00, 4'd4, 8'h01, 32'h33221115},
    {64'hD2_00_00_AA_00_00_00_00, 4'd4, 8'h03, 32'h33221115},
    {64'hD2_00_21_AA_00_00_00_00, 4'd4, 8'h03, 32'h33221115},
    {64'hD2_00_20_08_44_55_66_00, 4'd7, 8'h7F, 32'h6655441D},
    {64'hD2_00_05_20_01_02_03_04, 4'd8, 8'hFF, 32'h03020135},
    {64'hD2_00_01_80_77_00_00_00, 4'd5, 8'h0F, 32'h03020195}
  };
  localparam string VTAG [10] = '{"R5", "R6", "R2", "R2", "R3",
                                  "R4", "R4", "R4", "R7", "R7"};

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick();
    scl = 1'b1;   tick();
    sda_h = 1'b0; tick();
    scl = 1'b0;   tick();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick();
    scl = 1'b1;   tick();
    sda_h = 1'b1; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick();
      scl = 1'b1;   tick();
      scl = 1'b0;
    end
    sda_h = 1'b1; tick();
    scl = 1'b1;   tick();
    ack = ~sda_line;
    scl = 1'b0;   tick();
  endtask

  task automatic send_seq(input logic [63:0] bytes, input int n,
                          output logic [7:0] mask);
    logic a;
    mask = '0;
    for (int i = 0; i < n; i++) begin
      send_byte(bytes[63-8*i -: 8], a);
      mask[i] = a;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    check("R1 reset bank", regs, 32'h0000001D);
    check("R10 reset decode", {29'd0, spread_en, sel_48m, pci_run}, 32'd1);
    check("R11 idle release", {31'd0, sda_oe}, 32'd0);

    // table of transfers
    for (int v = 0; v < 10; v++) begin
      bus_start();
      send_seq(VECS[v][107:44], int'(VECS[v][43:40]), m);
      bus_stop();
      tick();
      check({VTAG[v], " ack pattern"}, {24'd0, m}, {24'd0, VECS[v][39:32]});
      check({VTAG[v], " bank"}, regs, VECS[v][31:0]);
    end
    check("R10 decode 0x95", {29'd0, spread_en, sel_48m, pci_run}, 32'd4);

    // R9: no new start after a NACK, a valid-looking sequence is ignored
    bus_start();
    send_seq(64'hD4_D2_00_01_80_00_00_00, 5, m);
    bus_stop(); tick();
    check("R9 ignored ack", {24'd0, m}, 32'd0);
    check("R9 ignored bank", regs, 32'h03020195);

    // R10: decode after writing 0x28
    bus_start();
    send_seq(64'hD2_00_01_28_00_00_00_00, 4, m);
    bus_stop(); tick();
    check("R10 bank", regs, 32'h0302013D);
    check("R10 decode 0x3D", {29'd0, spread_en, sel_48m, pci_run}, 32'd3);

    // R5: repeated start restarts at register 0
    bus_start();
    send_seq(64'hD2_00_02_C0_00_00_00_00, 4, m);
    bus_start();
    send_seq(64'hD2_00_01_00_00_00_00_00, 4, m);
    bus_stop(); tick();
    check("R5 restart ack", {24'd0, m}, 32'h0F);
    check("R5 restart bank", regs, 32'h03020115);

    // R8: straps change after reset, host writes zeros
    s2 = 1'b0; s1 = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 strap change", regs, 32'h03020115);
    bus_start();
    send_seq(64'hD2_00_01_06_00_00_00_00, 4, m);
    bus_stop(); tick();
    check("R8 host write", regs, 32'h03020115);

    // R1/R8: reset recaptures straps
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 R8 second reset", regs, 32'h0000001B);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule